// File: doc/BRIEF.md
# I2C Command Engine

This block is the bus-side engine of an I2C master. Software (or a DMA channel) first writes a command word that fixes what one transfer does: whether it opens with a START, whether it closes with a STOP, whether SCL stays held low afterwards, whether the master answers the final received byte with a NAK, which direction the data moves, and how many bytes move. A second command write with the run bit set then launches the transfer. Data passes through a single 32-bit word. A request flag asks the host for the next transmit word, or tells it that a received word is ready. The engine does not advance until the host acknowledges that flag.

The SCL and SDA pins are open-drain. The engine only ever pulls a line low or releases it. Bit timing comes from an external generator, which supplies one strobe per quarter bit period. In transmit mode the slave address byte is simply the first data byte, and it counts toward the byte total. A read from a slave is therefore done as two commands: a one-byte transmit that holds the clock, then a receive. Status bits report completion and a missing acknowledge. Two further status bits, bus-busy and engine-busy, stay set until a closing STOP has fully completed on the wires.

Top module: `i2c_cmd_engine`

## Requirements
- R1: A command write with bit 31 set acts as a soft reset. It returns the engine to idle, releases SCL and SDA, drops the data request and clears every status bit. The status word reads 0 in the following cycle.
- R2: A command write with bit 29 (run) clear and bit 31 clear only stores the fields and causes no bus activity. A write with bit 29 set starts a transfer from the fields already stored, and its other bits are ignored. Fields: bit 25 NAK on last, bit 21 hold clock, bit 20 STOP, bit 19 START, bit 16 direction (1 = transmit), bits 15:0 byte count.
- R3: With the START field set, SDA falls while SCL is released before the first bit. Without it, no START condition appears on the wires.
- R4: In transmit mode, bytes leave in ascending lane order: bits 7:0 of each data word first, then bits 15:8, and so on. Each byte is sent MSB first. The byte count includes the address byte.
- R5: In receive mode, the bytes that arrive are packed into `data_rdata` with the first one in bits 7:0. A final partial word carries its bytes in the low lanes, and its unused upper lanes read as zero.
- R6: `data_req` rises when a transmit word is needed, and when four received bytes (or the last ones) are ready. Only a `req_clr` pulse clears it. While it is set the engine holds SCL low and does not proceed.
- R7: Status bit 0 (complete) is set once the byte count is exhausted, after the STOP if one was requested. A run with a byte count of zero sets it at once with no bus activity.
- R8: A NAK from the slave on a transmitted byte sets status bit 1 and halts the engine with SCL held low. A write to the control port with bit 28 set clears the flag, releases both lines and returns the engine to idle. A control write without bit 28 has no effect.
- R9: In receive mode the master pulls SDA low to acknowledge each byte. The one exception: when NAK-on-last is set, the final byte is answered with SDA released.
- R10: With the STOP field set, SDA rises while SCL is released. Status bit 11 (bus busy) and bit 10 (engine busy) stay set until that STOP has finished, and both are clear afterwards.
- R11: A transfer without STOP leaves the bus claimed (bit 11 set). Its final SCL level depends on the hold-clock field: SCL is held low if the field is set and released if it is clear.
- R12: A partial final transmit word uses only its low lanes, up to the remaining count. Its upper lanes never reach the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_tick | input | 1 | One-cycle strobe per quarter bit period from the timing generator |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 28 releases a NAK halt |
| data_wr | input | 1 | Transmit data word write strobe |
| data_wdata | input | 32 | Transmit data word |
| req_clr | input | 1 | Acknowledges the data request |
| data_rdata | output | 32 | Received data word |
| data_req | output | 1 | Data request flag |
| status | output | 16 | Bit 11 bus busy, bit 10 engine busy, bit 1 no-ack, bit 0 complete; others zero |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The host's acknowledgement of a data request and a quarter-bit timing strobe can land in the same clock cycle. The engine must then act on both without losing the strobe's phase or reusing a stale word. The bench provokes this by waiting for a timing strobe and asserting `req_clr` in exactly that cycle, on every transmit word and every received word. A behavioural slave on the wires then judges the result: the byte stream it captures, the acknowledge levels it sees and the count of START and STOP conditions must all match the requirement text.

// File: rtl/i2c_eng_pkg.sv
`timescale 1ns/1ps
package i2c_eng_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int CNT_W      = 16;

  localparam int CMD_SRST    = 31;
  localparam int CMD_RUN     = 29;
  localparam int CMD_NAKLAST = 25;
  localparam int CMD_HOLD    = 21;
  localparam int CMD_STOP    = 20;
  localparam int CMD_START   = 19;
  localparam int CMD_DIR     = 16;
  localparam int CTL_RELEASE = 28;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WAIT, S_BIT, S_FIN, S_STOP, S_HALT
  } eng_state_t;

  typedef struct packed {
    logic             nak_last;
    logic             hold;
    logic             stop;
    logic             start;
    logic             tx;
    logic [CNT_W-1:0] count;
  } cmd_t;

  function automatic logic [7:0] lane_get(logic [WORD_W-1:0] w, logic [LANE_W-1:0] p);
    return w[8*p +: 8];
  endfunction
endpackage

// File: rtl/i2c_eng_cmdreg.sv
`timescale 1ns/1ps
module i2c_eng_cmdreg
  import i2c_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        engine_idle,
  output cmd_t        fields,
  output logic        run_go,
  output logic        srst
);
  logic latch_en;
  logic unused_cmd_bits;

  assign srst     = cmd_wr & cmd_wdata[CMD_SRST];
  assign run_go   = cmd_wr & cmd_wdata[CMD_RUN] & ~cmd_wdata[CMD_SRST] & engine_idle;
  assign latch_en = cmd_wr & ~cmd_wdata[CMD_RUN] & ~cmd_wdata[CMD_SRST];
  assign unused_cmd_bits = ^{cmd_wdata[30], cmd_wdata[28:26], cmd_wdata[24:22],
                             cmd_wdata[18:17]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fields <= '0;
    else if (srst) fields <= '0;
    else if (latch_en) begin
      fields.nak_last <= cmd_wdata[CMD_NAKLAST];
      fields.hold     <= cmd_wdata[CMD_HOLD];
      fields.stop     <= cmd_wdata[CMD_STOP];
      fields.start    <= cmd_wdata[CMD_START];
      fields.tx       <= cmd_wdata[CMD_DIR];
      fields.count    <= cmd_wdata[CNT_W-1:0];
    end
  end

  // R2: a run write never disturbs the stored fields
  p_run_keeps_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_go |=> $stable(fields));
endmodule

// File: rtl/i2c_eng_wordbuf.sv
`timescale 1ns/1ps
module i2c_eng_wordbuf #(
  parameter int NB = 4,
  localparam int W  = 8 * NB,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          data_wr,
  input  logic [W-1:0]  data_wdata,
  input  logic          rx_put,
  input  logic [PW-1:0] rx_pos,
  input  logic [7:0]    rx_byte,
  input  logic          rx_clr,
  output logic [W-1:0]  tx_word,
  output logic [W-1:0]  rx_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_word <= '0;
    else if (srst) tx_word <= '0;
    else if (data_wr) tx_word <= data_wdata;
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_word[8*i +: 8] <= '0;
      else if (srst || rx_clr) rx_word[8*i +: 8] <= '0;
      else if (rx_put && rx_pos == PW'(i)) rx_word[8*i +: 8] <= rx_byte;
    end
  end
endmodule

// File: rtl/i2c_cmd_engine.sv
`timescale 1ns/1ps
module i2c_cmd_engine
  import i2c_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        quarter_tick,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        data_wr,
  input  logic [31:0] data_wdata,
  input  logic        req_clr,
  output logic [31:0] data_rdata,
  output logic        data_req,
  output logic [15:0] status,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in
);
  cmd_t             fld;
  eng_state_t       state;
  logic             run_go, srst, release_hit, unused_ctl;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic [CNT_W-1:0] remaining;
  logic [LANE_W-1:0] pos;
  logic             req_q, done_q, nak_q, bus_q, ackbit, scl_lo, sda_lo;
  logic [WORD_W-1:0] tx_word;
  // named internal events
  logic             bit_end, rx_put, rx_clr, wait_exit;

  assign release_hit = ctl_wr & ctl_wdata[CTL_RELEASE];
  assign unused_ctl  = ^{ctl_wdata[31:29], ctl_wdata[27:0]};
  assign bit_end     = (state == S_BIT) && quarter_tick && (q == 2'd3) && (bitn == 4'd8);
  assign rx_put      = bit_end && !fld.tx;
  assign wait_exit   = (state == S_WAIT) && !req_q;
  assign rx_clr      = run_go || (wait_exit && !fld.tx);

  i2c_eng_cmdreg u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .engine_idle(state == S_IDLE), .fields(fld), .run_go(run_go), .srst(srst)
  );

  i2c_eng_wordbuf #(.NB(WORD_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .srst(srst), .data_wr(data_wr), .data_wdata(data_wdata),
    .rx_put(rx_put), .rx_pos(pos), .rx_byte(sh), .rx_clr(rx_clr),
    .tx_word(tx_word), .rx_word(data_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      state <= S_IDLE; q <= '0; bitn <= '0; sh <= '0; remaining <= '0; pos <= '0;
      req_q <= 1'b0; done_q <= 1'b0; nak_q <= 1'b0; bus_q <= 1'b0; ackbit <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (req_clr) req_q <= 1'b0;
      case (state)
        S_IDLE: if (run_go) begin
          done_q <= 1'b0;
          nak_q  <= 1'b0;
          if (fld.count == '0) done_q <= 1'b1;
          else begin
            remaining <= fld.count;
            pos       <= '0;
            bus_q     <= 1'b1;
            q         <= '0;
            bitn      <= '0;
            if (fld.start) state <= S_START;
            else if (fld.tx) begin req_q <= 1'b1; state <= S_WAIT; end
            else state <= S_BIT;
          end
        end
        S_START: if (quarter_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: begin scl_lo <= 1'b0; sda_lo <= 1'b0; end
            2'd1: sda_lo <= 1'b1;
            default: begin
              scl_lo <= 1'b1;
              q      <= '0;
              if (fld.tx) begin req_q <= 1'b1; state <= S_WAIT; end
              else state <= S_BIT;
            end
          endcase
        end
        S_WAIT: if (!req_q) begin
          q    <= '0;
          bitn <= '0;
          if (fld.tx) begin sh <= lane_get(tx_word, pos); state <= S_BIT; end
          else if (remaining == '0) state <= S_FIN;
          else state <= S_BIT;
        end
        S_BIT: if (quarter_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: begin
              scl_lo <= 1'b1;
              if (bitn == 4'd8) sda_lo <= !fld.tx && !(fld.nak_last && remaining == 1);
              else              sda_lo <= fld.tx && !sh[7];
            end
            2'd1: scl_lo <= 1'b0;
            2'd2: begin
              if (bitn == 4'd8) ackbit <= sda_in;
              else if (!fld.tx) sh <= {sh[6:0], sda_in};
            end
            default: begin
              scl_lo <= 1'b1;
              if (bitn != 4'd8) begin
                bitn <= bitn + 4'd1;
                if (fld.tx) sh <= {sh[6:0], 1'b0};
              end else begin
                bitn <= '0;
                if (fld.tx && ackbit) begin
                  nak_q <= 1'b1; sda_lo <= 1'b0; state <= S_HALT;
                end else begin
                  remaining <= remaining - 1'b1;
                  if (fld.tx) begin
                    if (remaining == 1) state <= S_FIN;
                    else if (pos == LANE_W'(WORD_BYTES - 1)) begin
                      pos <= '0; req_q <= 1'b1; state <= S_WAIT;
                    end else begin
                      pos <= pos + 1'b1;
                      sh  <= lane_get(tx_word, pos + 1'b1);
                    end
                  end else if (remaining == 1 || pos == LANE_W'(WORD_BYTES - 1)) begin
                    pos <= '0; req_q <= 1'b1; state <= S_WAIT;
                  end else pos <= pos + 1'b1;
                end
              end
            end
          endcase
        end
        S_FIN: begin
          q <= '0;
          if (fld.stop) state <= S_STOP;
          else begin
            done_q <= 1'b1; scl_lo <= fld.hold; sda_lo <= 1'b0; state <= S_IDLE;
          end
        end
        S_STOP: if (quarter_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
            2'd1: scl_lo <= 1'b0;
            default: begin
              sda_lo <= 1'b0; done_q <= 1'b1; bus_q <= 1'b0; state <= S_IDLE;
            end
          endcase
        end
        S_HALT: if (release_hit) begin
          nak_q <= 1'b0; bus_q <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign data_req      = req_q;
  assign scl_drive_low = scl_lo;
  assign sda_drive_low = sda_lo;
  assign status = {4'b0, bus_q, (state != S_IDLE), 8'b0, nak_q, done_q};

  // R1: an idle engine with a free bus leaves both lines released
  p_idle_lines_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !bus_q) |-> (!scl_lo && !sda_lo));
  // R6: the request flag only exists while the engine is parked
  p_req_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (state == S_WAIT));
  // R6: no clock edge is produced while waiting for the host
  p_wait_no_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && $past(state == S_WAIT)) |-> $stable(scl_lo));
  // R8: a no-ack halts with SCL held low
  p_nak_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nak_q |-> (state == S_HALT && scl_lo));
  // R7: completion is only reported from idle
  p_done_in_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state == S_IDLE));
  // R10: bus busy drops only with SDA released and the engine idle
  p_busy_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_q) |-> (state == S_IDLE && !sda_lo));
endmodule

// File: tb/i2c_cmd_engine_test.sv
`timescale 1ns/1ps
module i2c_cmd_engine_test;
  localparam logic [31:0] F_NAK = 32'h1 << 25, F_HOLD = 32'h1 << 21, F_STOP = 32'h1 << 20,
                          F_START = 32'h1 << 19, F_MST = 32'h1 << 17, F_TX = 32'h1 << 16,
                          RUN = 32'h1 << 29, SRST = 32'h1 << 31, REL = 32'h1 << 28;

  logic clk = 1'b0, rst_n = 1'b0, quarter_tick = 1'b0;
  logic cmd_wr = 1'b0, ctl_wr = 1'b0, data_wr = 1'b0, req_clr = 1'b0;
  logic [31:0] cmd_wdata = '0, ctl_wdata = '0, data_wdata = '0, data_rdata;
  logic data_req, scl_oe, sda_oe;
  logic [15:0] status;
  logic pull = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | pull);

  int checks = 0, errors = 0;
  bit finished = 0;

  i2c_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .quarter_tick(quarter_tick), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .data_wr(data_wr),
    .data_wdata(data_wdata), .req_clr(req_clr), .data_rdata(data_rdata),
    .data_req(data_req), .status(status), .scl_drive_low(scl_oe),
    .sda_drive_low(sda_oe), .sda_in(sda_w)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    quarter_tick = 1'b1;
    @(negedge clk);
    quarter_tick = 1'b0;
  end

  // behavioural slave, configured by the tests
  bit mode_rx = 0;
  int nak_at = -1;
  logic [7:0] rxb [0:7];
  logic kick = 1'b0;
  logic kick_prev = 1'b0, scl_prev = 1'b1, sda_prev = 1'b1;
  int bc = 0, cap_n = 0, mack_n = 0, rx_i = 0, starts = 0, stops = 0, falls = 0;
  logic [7:0] ssh = '0;
  logic [7:0] cap [0:15];
  logic mack [0:15];

  always @(scl_w or sda_w or kick) begin
    if (kick != kick_prev) begin
      bc = 0; cap_n = 0; mack_n = 0; rx_i = 0; starts = 0; stops = 0; falls = 0;
      pull = mode_rx ? ~rxb[0][7] : 1'b0;
    end else if (scl_w && !scl_prev) begin
      if (bc < 8) begin
        ssh = {ssh[6:0], sda_w};
        if (bc == 7 && !mode_rx && cap_n < 16) begin cap[cap_n] = ssh; cap_n++; end
      end else if (mode_rx) begin
        if (mack_n < 16) mack[mack_n] = sda_w;
        mack_n++;
        if (rx_i < 7) rx_i++;
      end
      bc = (bc == 8) ? 0 : bc + 1;
    end else if (!scl_w && scl_prev) begin
      falls++;
      if (bc == 8) pull = !mode_rx && ((cap_n - 1) != nak_at);
      else if (mode_rx) pull = ~rxb[rx_i][7 - bc];
      else pull = 1'b0;
    end else if (!sda_w && sda_prev && scl_w) begin
      starts++; bc = 0; pull = 1'b0;
    end else if (sda_w && !sda_prev && scl_w) begin
      stops++;
    end
    kick_prev = kick; scl_prev = scl_w; sda_prev = sda_w;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic slave_reset(input bit rx);
    mode_rx = rx;
    kick = ~kick;
    #1;
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic ctl(input logic [31:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wait_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin @(negedge clk); ok = data_req; end
  endtask

  task automatic wait_stat(input int bitpos, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin @(negedge clk); ok = status[bitpos]; end
  endtask

  // acknowledge in the very cycle of a timing strobe
  task automatic ack_on_tick();
    do @(negedge clk); while (!quarter_tick);
    req_clr = 1'b1;
    @(negedge clk); req_clr = 1'b0;
  endtask

  task automatic feed(input logic [31:0] w, input string tag);
    bit ok;
    wait_req(ok);
    chk(ok, {tag, ": transmit word requested"}, 32'(data_req), 32'd1);
    @(negedge clk); data_wr = 1'b1; data_wdata = w;
    @(negedge clk); data_wr = 1'b0;
    ack_on_tick();
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(status == 16'h0, "R1 status after reset", 32'(status), 32'h0);
    chk(!data_req && scl_w && sda_w, "R1 lines/request after reset",
        {29'b0, data_req, scl_w, sda_w}, 32'h3);
  endtask

  task automatic test_tx_write();
    bit ok;
    slave_reset(0);
    cmd(F_START | F_STOP | F_MST | F_TX | 32'd6);
    repeat (80) @(negedge clk);
    chk(falls == 0 && !data_req && status == 0, "R2 field write alone stays quiet",
        32'(falls), 32'd0);
    cmd(RUN);
    wait_req(ok);
    chk(status[11] && status[10], "R10 busy bits during transfer", 32'(status), 32'h0c00);
    chk(starts == 1, "R3 START before first bit", 32'(starts), 32'd1);
    feed(32'h5A3C11A0, "R6");
    feed(32'hFFEE7788, "R6");
    wait_stat(0, ok);
    chk(ok, "R7 complete after count exhausted", 32'(status), 32'h1);
    chk(cap_n == 6, "R12 only remaining lanes sent", 32'(cap_n), 32'd6);
    chk({cap[0], cap[1], cap[2], cap[3]} == 32'hA0113C5A, "R4 lane order word 0",
        {cap[0], cap[1], cap[2], cap[3]}, 32'hA0113C5A);
    chk({cap[4], cap[5]} == 16'h8877, "R12 partial word low lanes", 32'({cap[4], cap[5]}), 32'h8877);
    chk(stops == 1, "R10 STOP on the wires", 32'(stops), 32'd1);
    chk(status == 16'h0001 && !data_req, "R10 busy bits clear after STOP", 32'(status), 32'h1);
  endtask

  task automatic test_nak();
    bit ok;
    slave_reset(0);
    nak_at = 1;
    cmd(F_START | F_STOP | F_MST | F_TX | 32'd4);
    cmd(RUN);
    feed(32'h04030290, "R8");
    wait_stat(1, ok);
    repeat (40) @(negedge clk);
    chk(ok && !status[0] && status[10], "R8 no-ack halts", 32'(status), 32'h0c02);
    chk(!scl_w, "R8 SCL held low in halt", 32'(scl_w), 32'd0);
    chk(cap_n == 2, "R8 no byte after NAK", 32'(cap_n), 32'd2);
    ctl(32'h0FFF_FFFF);
    repeat (10) @(negedge clk);
    chk(status[1] && !scl_w, "R8 control write without release ignored", 32'(status), 32'h0c02);
    ctl(REL);
    @(negedge clk);
    chk(status == 16'h0 && scl_w && sda_w, "R8 release returns to idle", 32'(status), 32'h0);
    nak_at = -1;
  endtask

  task automatic test_select_read();
    bit ok;
    slave_reset(0);
    cmd(F_START | F_HOLD | F_MST | F_TX | 32'd1);
    cmd(RUN);
    feed(32'hDEAD_BEA1, "R12");
    wait_stat(0, ok);
    repeat (20) @(negedge clk);
    chk(ok && status == 16'h0801, "R11 claimed bus after select", 32'(status), 32'h0801);
    chk(!scl_w && stops == 0 && cap_n == 1 && cap[0] == 8'hA1, "R11 SCL held low, one byte",
        {23'b0, scl_w, cap[0]}, 32'h00A1);
    rxb[0] = 8'h12; rxb[1] = 8'h34; rxb[2] = 8'h56; rxb[3] = 8'h78;
    rxb[4] = 8'h9A; rxb[5] = 8'hFF; rxb[6] = 8'hFF; rxb[7] = 8'hFF;
    slave_reset(1);
    cmd(F_STOP | F_NAK | F_MST | 32'd5);
    cmd(RUN);
    wait_req(ok);
    chk(ok && data_rdata == 32'h78563412, "R5 first received word", data_rdata, 32'h78563412);
    ack_on_tick();
    wait_req(ok);
    chk(ok && data_rdata == 32'h0000009A, "R5 partial word, upper lanes zero",
        data_rdata, 32'h0000009A);
    ack_on_tick();
    wait_stat(0, ok);
    chk(ok, "R7 receive complete", 32'(status), 32'h1);
    chk(mack_n == 5 && {mack[0], mack[1], mack[2], mack[3], mack[4]} == 5'b00001,
        "R9 ACK levels, NAK on last", 32'({mack[0], mack[1], mack[2], mack[3], mack[4]}), 32'h1);
    chk(starts == 0, "R3 no START without field", 32'(starts), 32'd0);
    chk(stops == 1 && status == 16'h0001, "R10 STOP ends read", 32'(stops), 32'd1);
  endtask

  task automatic test_zero();
    slave_reset(0);
    cmd(F_START | F_STOP | F_MST | F_TX | 32'd0);
    cmd(RUN);
    @(negedge clk);
    chk(status == 16'h0001, "R7 zero count completes at once", 32'(status), 32'h1);
    repeat (40) @(negedge clk);
    chk(falls == 0 && starts == 0 && !data_req, "R7 zero count no bus activity",
        32'(falls), 32'd0);
  endtask

  task automatic test_no_hold();
    bit ok;
    slave_reset(0);
    cmd(F_START | F_MST | F_TX | 32'd1);
    cmd(RUN);
    feed(32'h0000_0042, "R11");
    wait_stat(0, ok);
    repeat (10) @(negedge clk);
    chk(ok && scl_w && stops == 0 && status[11], "R11 SCL released without hold",
        {30'b0, scl_w, status[11]}, 32'h3);
  endtask

  task automatic test_soft_reset();
    bit ok;
    slave_reset(0);
    cmd(F_START | F_STOP | F_MST | F_TX | 32'd3);
    cmd(RUN);
    wait_req(ok);
    chk(ok && status[11], "R1 transfer in flight", 32'(status), 32'h0c00);
    cmd(SRST);
    chk(status == 16'h0 && !data_req && scl_w && sda_w, "R1 soft reset clears all",
        32'(status), 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_tx_write();
    test_nak();
    test_select_read();
    test_zero();
    test_no_hold();
    test_soft_reset();
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule